// File: doc/BRIEF.md
# Lookup Bus Transmit Formatter

This block sits between a line card's ingress queue and a shared lookup bus that is 16 bytes wide. It reads a packet stream marked with start and end flags, along with a summary header prepared beforehand. It then puts onto the bus the form of that packet which every receiver on the bus can accept. The transfer form comes from a chassis configuration input.

- **Flowthrough** copies the whole packet onto the bus, ends with a byte-enable mask on the final beat, and follows it with one idle wait cycle.
- **Compact** replaces the packet with its two-beat summary header. It adds no wait cycle.
- **Truncated** is the form that stays safe when older receivers share the bus. It always sends a 64-byte frame that keeps the leading layer-2/layer-3 header bytes and zeroes everything else. One wait cycle follows the frame.

The mode is sampled only when a packet starts, so a configuration change never splits a transfer. Any packet beats that the chosen form does not carry are taken from the queue silently.

Top module: `lkbus_tx_fmt`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `bus_valid` and `bus_wait` are low and `in_ready` is high.
- R2: `cfg_mode` encodings:
  - 0 selects flowthrough.
  - 1 selects compact.
  - 2 selects truncated.
  - 3 is treated exactly as truncated.
- R3: In flowthrough, every input beat appears on `bus_data` unchanged, in order, in the cycle after it is accepted. `bus_be` is all ones except on the end beat, where bit i is set only for i < `in_bytes`. Byte i of a beat occupies bits 8i+7..8i.
- R4: In flowthrough, exactly one cycle with `bus_wait` high and `bus_valid` low follows the end beat directly. `in_ready` is low in the cycle in which the end beat is on the bus.
- R5: In compact, exactly two beats are sent: `cmp_hdr` bits 127..0, then bits 255..128, both as sampled when the start beat is accepted. `bus_be` is all ones and no wait cycle follows.
- R6: In truncated, exactly four beats are sent. Byte p = 16*beat+lane carries packet byte p when p < KEEP_BYTES (default 34) and p is within the packet. Otherwise it carries zero. `bus_be` is all ones.
- R7: In truncated, a packet shorter than 64 bytes is completed with zero beats while `in_ready` is low. Beats of a longer packet past byte 63 are consumed without any bus output.
- R8: In truncated, exactly one wait cycle follows the fourth beat, and `in_ready` is low in the cycle in which that beat is on the bus.
- R9: The mode is sampled only when a start beat is accepted. Changes of `cfg_mode` while a packet is being handled have no effect on that packet.
- R10: An input beat without `in_sop` that arrives while no packet is in progress is consumed and produces no bus output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Transfer mode selection from chassis configuration |
| in_valid | input | 1 | Ingress beat valid |
| in_ready | output | 1 | Ingress beat accepted when high together with in_valid |
| in_sop | input | 1 | Beat is the first of a packet |
| in_eop | input | 1 | Beat is the last of a packet |
| in_bytes | input | 5 | Valid byte count (1..16) of the end beat |
| in_data | input | 128 | Ingress beat data, byte i at bits 8i+7..8i |
| cmp_hdr | input | 256 | Precomputed 32-byte summary header, valid with the start beat |
| bus_valid | output | 1 | Bus beat valid |
| bus_wait | output | 1 | Bus wait cycle |
| bus_data | output | 128 | Bus beat data |
| bus_be | output | 16 | Bus byte enables |

## Verification
Every bus output is registered, so each result is due in a predictable cycle:
- A pass-through or first header beat appears one cycle after the clock edge that accepts its input beat.
- The second compact beat and each zero pad beat follow in consecutive cycles.
- The wait cycle lands in the cycle right after the last beat.

The bench therefore samples outputs at the falling edge. It compares each active bus cycle, in strict order, with a queue of beats and wait cycles computed arithmetically from the packet length and mode when the packet is issued. This catches any missing, extra or shifted cycle. The `in_ready` checks are tied to the cycle in which the last beat is visible.

// File: rtl/lkb_pkg.sv
`timescale 1ns/1ps
package lkb_pkg;

    localparam int BEAT_BYTES_DEF  = 16;
    localparam int FRAME_BYTES_DEF = 64;
    localparam int KEEP_BYTES_DEF  = 34;

    typedef enum logic [1:0] {
        MODE_FLOW  = 2'd0,
        MODE_CMP   = 2'd1,
        MODE_TRUNC = 2'd2,
        MODE_RSVD  = 2'd3
    } xfer_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLOW,
        ST_CHI,
        ST_TR,
        ST_PAD,
        ST_WAIT,
        ST_DRAIN
    } fmt_state_e;

    typedef enum logic [2:0] {
        EM_NONE,
        EM_PASS,
        EM_CLO,
        EM_CHI,
        EM_TRUNC,
        EM_ZERO,
        EM_WAIT
    } emit_kind_e;

    typedef struct packed {
        emit_kind_e kind;
        logic       last;
    } emit_t;

    // Reserved encoding falls back to the form every receiver accepts.
    function automatic xfer_mode_e norm_mode(input logic [1:0] m);
        xfer_mode_e r;
        case (m)
            2'd0:    r = MODE_FLOW;
            2'd1:    r = MODE_CMP;
            default: r = MODE_TRUNC;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lkb_lane_mask.sv
`timescale 1ns/1ps
module lkb_lane_mask #(
    parameter int LANES = 16,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic [CNT_W-1:0] count,
    output logic [LANES-1:0] lane_en
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_en[i] = (32'(count) > 32'(i));
    end
endmodule

// File: rtl/lkb_trunc_mask.sv
`timescale 1ns/1ps
module lkb_trunc_mask #(
    parameter int BEAT_BYTES = 16,
    parameter int KEEP_BYTES = 34,
    parameter int IDX_W      = 2,
    localparam int BEAT_W    = BEAT_BYTES * 8
) (
    input  logic [BEAT_W-1:0]     data_in,
    input  logic [IDX_W-1:0]      beat_idx,
    input  logic                  last,
    input  logic [BEAT_BYTES-1:0] tail_en,
    output logic [BEAT_W-1:0]     data_out
);
    for (genvar i = 0; i < BEAT_BYTES; i++) begin : g_byte
        logic in_hdr;
        logic in_pkt;
        assign in_hdr = (32'(beat_idx) * 32'(BEAT_BYTES) + 32'(i)) < 32'(KEEP_BYTES);
        assign in_pkt = !last || tail_en[i];
        assign data_out[8*i +: 8] = (in_hdr && in_pkt) ? data_in[8*i +: 8] : 8'h00;
    end
endmodule

// File: rtl/lkb_ctrl.sv
`timescale 1ns/1ps
module lkb_ctrl
    import lkb_pkg::*;
#(
    parameter int FRAME_BEATS = 4,
    localparam int IDX_W = (FRAME_BEATS > 1) ? $clog2(FRAME_BEATS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_mode,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    output logic             in_ready,
    output emit_t            emit,
    output logic [IDX_W-1:0] beat_idx,
    output xfer_mode_e       mode_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BEATS - 1);

    fmt_state_e       state_q, state_n;
    xfer_mode_e       mode_q, mode_n;
    logic [IDX_W-1:0] cnt_q, cnt_n;
    logic             drain_q, drain_n;
    logic             accept;
    logic             tr_take;

    always_comb begin
        case (state_q)
            ST_IDLE, ST_FLOW, ST_TR, ST_DRAIN: in_ready = 1'b1;
            default:                           in_ready = 1'b0;
        endcase
    end

    assign accept   = in_valid && in_ready;
    assign beat_idx = cnt_q;
    assign mode_o   = mode_q;

    always_comb begin
        state_n = state_q;
        mode_n  = mode_q;
        cnt_n   = cnt_q;
        drain_n = drain_q;
        tr_take = 1'b0;
        emit    = '{kind: EM_NONE, last: 1'b0};
        case (state_q)
            ST_IDLE: begin
                if (accept && in_sop) begin
                    mode_n = norm_mode(cfg_mode);
                    case (mode_n)
                        MODE_FLOW: begin
                            emit    = '{kind: EM_PASS, last: in_eop};
                            state_n = in_eop ? ST_WAIT : ST_FLOW;
                        end
                        MODE_CMP: begin
                            emit    = '{kind: EM_CLO, last: 1'b0};
                            drain_n = !in_eop;
                            state_n = ST_CHI;
                        end
                        default: tr_take = 1'b1;
                    endcase
                end
            end
            ST_FLOW: begin
                if (accept) begin
                    emit = '{kind: EM_PASS, last: in_eop};
                    if (in_eop) state_n = ST_WAIT;
                end
            end
            ST_CHI: begin
                emit    = '{kind: EM_CHI, last: 1'b1};
                state_n = drain_q ? ST_DRAIN : ST_IDLE;
            end
            ST_TR: begin
                if (accept) tr_take = 1'b1;
            end
            ST_PAD: begin
                emit = '{kind: EM_ZERO, last: 1'b0};
                if (cnt_q == LAST_IDX) begin
                    state_n = ST_WAIT;
                    drain_n = 1'b0;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_WAIT: begin
                emit    = '{kind: EM_WAIT, last: 1'b0};
                state_n = drain_q ? ST_DRAIN : ST_IDLE;
            end
            ST_DRAIN: begin
                if (accept && in_eop) begin
                    state_n = ST_IDLE;
                    drain_n = 1'b0;
                end
            end
            default: state_n = ST_IDLE;
        endcase

        if (tr_take) begin
            emit = '{kind: EM_TRUNC, last: in_eop};
            if (cnt_q == LAST_IDX) begin
                state_n = ST_WAIT;
                drain_n = !in_eop;
                cnt_n   = '0;
            end else begin
                cnt_n   = cnt_q + 1'b1;
                state_n = in_eop ? ST_PAD : ST_TR;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_FLOW;
            cnt_q   <= '0;
            drain_q <= 1'b0;
        end else begin
            state_q <= state_n;
            mode_q  <= mode_n;
            cnt_q   <= cnt_n;
            drain_q <= drain_n;
        end
    end

    // R9: the latched mode moves only on an accepted start beat
    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(accept && in_sop && state_q == ST_IDLE) |=> $stable(mode_q));

    // R5: the second compact header beat is never followed by a wait cycle
    assert_compact_no_wait_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHI) |=> (state_q != ST_WAIT));

endmodule

// File: rtl/lkbus_tx_fmt.sv
`timescale 1ns/1ps
module lkbus_tx_fmt
    import lkb_pkg::*;
#(
    parameter int BEAT_BYTES  = BEAT_BYTES_DEF,
    parameter int FRAME_BYTES = FRAME_BYTES_DEF,
    parameter int KEEP_BYTES  = KEEP_BYTES_DEF,
    localparam int BEAT_W      = BEAT_BYTES * 8,
    localparam int BCNT_W      = $clog2(BEAT_BYTES + 1),
    localparam int FRAME_BEATS = FRAME_BYTES / BEAT_BYTES,
    localparam int IDX_W       = (FRAME_BEATS > 1) ? $clog2(FRAME_BEATS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            cfg_mode,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic                  in_sop,
    input  logic                  in_eop,
    input  logic [BCNT_W-1:0]     in_bytes,
    input  logic [BEAT_W-1:0]     in_data,
    input  logic [2*BEAT_W-1:0]   cmp_hdr,
    output logic                  bus_valid,
    output logic                  bus_wait,
    output logic [BEAT_W-1:0]     bus_data,
    output logic [BEAT_BYTES-1:0] bus_be
);
    emit_t               emit;
    logic [IDX_W-1:0]    beat_idx;
    xfer_mode_e          mode_q;
    logic [BEAT_BYTES-1:0] tail_en;
    logic [BEAT_W-1:0]   trunc_data;
    logic [BEAT_W-1:0]   hdr_hi_q;

    lkb_ctrl #(.FRAME_BEATS(FRAME_BEATS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cfg_mode (cfg_mode),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .in_ready (in_ready),
        .emit     (emit),
        .beat_idx (beat_idx),
        .mode_o   (mode_q)
    );

    lkb_lane_mask #(.LANES(BEAT_BYTES)) u_tail (
        .count   (in_bytes),
        .lane_en (tail_en)
    );

    lkb_trunc_mask #(
        .BEAT_BYTES (BEAT_BYTES),
        .KEEP_BYTES (KEEP_BYTES),
        .IDX_W      (IDX_W)
    ) u_trunc (
        .data_in  (in_data),
        .beat_idx (beat_idx),
        .last     (in_eop),
        .tail_en  (tail_en),
        .data_out (trunc_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_hi_q <= '0;
        end else if (emit.kind == EM_CLO) begin
            hdr_hi_q <= cmp_hdr[2*BEAT_W-1:BEAT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_valid <= 1'b0;
            bus_wait  <= 1'b0;
            bus_data  <= '0;
            bus_be    <= '0;
        end else begin
            bus_valid <= 1'b0;
            bus_wait  <= 1'b0;
            bus_data  <= '0;
            bus_be    <= '0;
            case (emit.kind)
                EM_PASS: begin
                    bus_valid <= 1'b1;
                    bus_data  <= in_data;
                    bus_be    <= emit.last ? tail_en : '1;
                end
                EM_CLO: begin
                    bus_valid <= 1'b1;
                    bus_data  <= cmp_hdr[BEAT_W-1:0];
                    bus_be    <= '1;
                end
                EM_CHI: begin
                    bus_valid <= 1'b1;
                    bus_data  <= hdr_hi_q;
                    bus_be    <= '1;
                end
                EM_TRUNC: begin
                    bus_valid <= 1'b1;
                    bus_data  <= trunc_data;
                    bus_be    <= '1;
                end
                EM_ZERO: begin
                    bus_valid <= 1'b1;
                    bus_be    <= '1;
                end
                EM_WAIT: bus_wait <= 1'b1;
                default: ;
            endcase
        end
    end

    // R4: a wait cycle carries no beat
    assert_wait_not_valid_R4: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && bus_wait));

    // R4/R8: a wait cycle directly follows a beat
    assert_wait_after_beat_R4: assert property (@(posedge clk) disable iff (rst)
        bus_wait |-> $past(bus_valid));

    // R8: wait cycles are single
    assert_single_wait_R8: assert property (@(posedge clk) disable iff (rst)
        bus_wait |=> !bus_wait);

    // R3: only flowthrough may carry a partial byte-enable mask
    assert_partial_be_flow_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_be != '1) |-> (mode_q == MODE_FLOW));

endmodule

// File: tb/tb_lkbus_tx_fmt.sv
`timescale 1ns/1ps
module tb_lkbus_tx_fmt;
    localparam int BB   = 16;
    localparam int BW   = BB * 8;
    localparam int KEEP = 34;
    localparam int FRM  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_mode = 2'd0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          in_sop = 1'b0;
    logic          in_eop = 1'b0;
    logic [4:0]    in_bytes = 5'd16;
    logic [BW-1:0] in_data = '0;
    logic [2*BW-1:0] cmp_hdr = '0;
    logic          bus_valid;
    logic          bus_wait;
    logic [BW-1:0] bus_data;
    logic [BB-1:0] bus_be;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    bit mon_on = 1'b0;

    typedef struct {
        bit            w;
        logic [BW-1:0] d;
        logic [BB-1:0] be;
        bit            rl;
        string         tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    lkbus_tx_fmt dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_sop(in_sop), .in_eop(in_eop), .in_bytes(in_bytes),
        .in_data(in_data), .cmp_hdr(cmp_hdr),
        .bus_valid(bus_valid), .bus_wait(bus_wait),
        .bus_data(bus_data), .bus_be(bus_be)
    );

    function automatic logic [7:0] pbyte(int k, int p);
        return 8'((p * 7 + k * 13 + 1) & 255);
    endfunction

    function automatic logic [BB-1:0] tail_mask(int n);
        logic [BB-1:0] m;
        m = '0;
        for (int i = 0; i < BB; i++) if (i < n) m[i] = 1'b1;
        return m;
    endfunction

    task automatic check(string tag, string what, logic [BW-1:0] act, logic [BW-1:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic push(bit w, logic [BW-1:0] d, logic [BB-1:0] be, bit rl, string tag);
        exp_t e;
        e.w = w; e.d = d; e.be = be; e.rl = rl; e.tag = tag;
        exp_q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (mon_on && !rst && (bus_valid || bus_wait)) begin
            if (exp_q.size() == 0) begin
                check("R10", "unexpected bus cycle", BW'({bus_valid, bus_wait}), '0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, "wait flag", BW'(bus_wait), BW'(e.w));
                check(e.tag, "valid flag", BW'(bus_valid), BW'(!e.w));
                if (!e.w) begin
                    check(e.tag, "data", bus_data, e.d);
                    check(e.tag, "byte enables", BW'(bus_be), BW'(e.be));
                end
                if (e.rl) check(e.w ? e.tag : (e.tag == "R3" ? "R4" : "R8"),
                                "in_ready at last beat", BW'(in_ready), '0);
            end
        end
    end

    task automatic run_pkt(int k, int mode, int len);
        int nb;
        int eff;
        logic [2*BW-1:0] hdr;
        logic [BW-1:0] d;
        nb  = (len + BB - 1) / BB;
        eff = (mode == 3) ? 2 : mode;
        for (int j = 0; j < 2 * BB; j++) hdr[8*j +: 8] = 8'((j * 5 + k * 3 + 64) & 255);
        if (eff == 0) begin
            // R3 beats, then R4 wait
            for (int b = 0; b < nb; b++) begin
                for (int i = 0; i < BB; i++)
                    d[8*i +: 8] = (b * BB + i < len) ? pbyte(k, b * BB + i) : 8'hEE;
                push(1'b0, d, (b == nb - 1) ? tail_mask(len - b * BB) : '1, b == nb - 1, "R3");
            end
            push(1'b1, '0, '0, 1'b0, "R4");
        end else if (eff == 1) begin
            push(1'b0, hdr[BW-1:0], '1, 1'b0, "R5");
            push(1'b0, hdr[2*BW-1:BW], '1, 1'b0, "R5");
        end else begin
            // R6 content, R7 pad/cut, R8 wait; mode 3 checks R2
            for (int b = 0; b < FRM; b++) begin
                for (int i = 0; i < BB; i++) begin
                    int p;
                    p = b * BB + i;
                    d[8*i +: 8] = (p < len && p < KEEP) ? pbyte(k, p) : 8'h00;
                end
                push(1'b0, d, '1, b == FRM - 1, (mode == 3) ? "R2" : (len < 64 ? "R7" : "R6"));
            end
            push(1'b1, '0, '0, 1'b0, "R8");
        end
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (b == 0);
            in_eop   = (b == nb - 1);
            in_bytes = (b == nb - 1) ? 5'(len - b * BB) : 5'(BB);
            for (int i = 0; i < BB; i++)
                in_data[8*i +: 8] = (b * BB + i < len) ? pbyte(k, b * BB + i) : 8'hEE;
            // R9: mode and header disturbed after the start beat
            cfg_mode = (b == 0) ? 2'(mode) : 2'((mode + 1) % 4);
            cmp_hdr  = (b == 0) ? hdr : ~hdr;
            while (!in_ready) @(negedge clk);
        end
    endtask

    task automatic stray_beat();
        // R10: beat without start marker while idle
        @(negedge clk);
        in_valid = 1'b1;
        in_sop   = 1'b0;
        in_eop   = 1'b1;
        in_bytes = 5'd16;
        in_data  = {BB{8'h5A}};
        cfg_mode = 2'd1;
        while (!in_ready) @(negedge clk);
    endtask

    initial begin
        int k;
        repeat (4) @(negedge clk);
        check("R1", "bus_valid in reset", BW'(bus_valid), '0);
        check("R1", "bus_wait in reset", BW'(bus_wait), '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "bus_valid after reset", BW'(bus_valid), '0);
        check("R1", "bus_wait after reset", BW'(bus_wait), '0);
        check("R1", "in_ready after reset", BW'(in_ready), BW'(1));
        mon_on = 1'b1;
        k = 0;
        for (int m = 0; m < 4; m++) begin
            for (int len = 1; len <= 90; len++) begin
                run_pkt(k, m, len);
                k++;
                if (k % 17 == 0) stray_beat();
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (20) @(negedge clk);
        check("R10", "outstanding expected cycles", BW'(exp_q.size()), '0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule